// File: doc/BRIEF.md
# External Memory Cycle Sequencer with Wait Stretching

This block runs one external memory access at a time for a processor core. An access is a fixed walk through six phases, T1 to T6. Each phase lasts a parameterised number of periods of the fast timing clock `clk`. One such period is called Tm. The block drives the strobes for a multiplexed address/data bus from the current phase:

- an address-latch pulse;
- an active-low chip enable;
- an active-low read strobe;
- per-byte active-low write strobes, with an early or a late mode;
- a bus output enable, with the value to drive on the bus.

The block also produces `ck_out`, a bus clock that toggles once every Tm. One bus clock cycle is therefore two Tm periods.

External slow devices hold `mem_wait` high to lengthen T4. The wait input passes through a synchroniser first. T4 then grows by one Tm for every period in which the synchronised wait is seen high at the point where T4 would end.

If waits were added and T5 would then begin on a falling edge of `ck_out`, one extra alignment period (EW) is placed before T5. T5 then begins on a rising edge. Accesses flagged as internal ignore the wait input altogether.

The core starts an access by holding `start` together with the request fields until `busy` rises. It sees `done` for one cycle in the last period of T6.

Top module: `emc_cycle_seq`

## Requirements
- R1: `phase` reports the current phase with these codes: 0 idle, 1 to 6 for T1 to T6, 7 for EW. An access runs 1,2,3,4,(7),5,6 and then returns to 0. `start` is accepted only in idle, on a clock edge where `ck_out` is low, so that T1 always begins with `ck_out` high.
- R2: Phases T1, T2, T3, T5 and T6 each last exactly their length parameter in `clk` periods. T4 lasts at least LEN_T4 periods.
- R3: `ck_out` is low in reset and inverts on every `clk` edge after reset.
- R4: `mem_wait` passes through SYNC_STAGES flops. It is looked at only in periods where T4 has reached its base length. In each such period where the synchronised value is high, T4 lasts one more period. T4 keeps stretching for as long as the synchronised wait stays high.
- R5: For an access started with `start_internal` high, T4 lasts exactly LEN_T4 periods whatever `mem_wait` does.
- R6: After T4, one EW period (code 7) follows if and only if T4 was stretched and `ck_out` is high in the last T4 period. In that case T5 begins with `ck_out` high. An unstretched T4 goes straight to T5 whatever the parity.
- R7: `ale` is high exactly in T1. `ce_n` is low exactly in T2, T3, T4, EW and T5.
- R8: On a write, `wr_n[b]` is low only when byte enable b was set. In early mode it is low in T2, T3, T4 and EW; in late mode it is low in T3, T4 and EW. It is high in every other phase and on reads.
- R9: `ad_oe` is high in T1 for every access, and in T2 to T6 for writes. `ad_out` carries the latched address in T1 and the latched write data in every other phase, so data stays driven through T5 and T6, after the write strobes rise.
- R10: On a read, `rd_n` is low in T3, T4 and EW. `rdata` takes `ad_in` on the clock edge that ends T4.
- R11: `done` is high only in the last period of T6, for one cycle. `busy` is high whenever `phase` is not 0.
- R12: During reset `phase` is 0, `ck_out` is low, `busy` and `done` are low, `ce_n`, `rd_n` and all `wr_n` bits are high, and `ale` and `ad_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | timing clock, one period is Tm |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | access request, held until `busy` rises |
| start_we | input | 1 | 1 write, 0 read |
| start_late | input | 1 | 1 late-write strobes, 0 early |
| start_internal | input | 1 | access ignores the wait input |
| start_addr | input | DW | address |
| start_wdata | input | DW | write data |
| start_be | input | DW/8 | byte enables |
| mem_wait | input | 1 | asynchronous wait request |
| ad_in | input | DW | bus value sampled for reads |
| ck_out | output | 1 | bus clock, toggles every Tm |
| phase | output | 3 | current phase code |
| busy | output | 1 | access in progress |
| done | output | 1 | last period of T6 |
| ale | output | 1 | address latch pulse |
| ce_n | output | 1 | chip enable, active low |
| rd_n | output | 1 | read strobe, active low |
| wr_n | output | DW/8 | byte write strobes, active low |
| ad_oe | output | 1 | bus output enable |
| ad_out | output | DW | value driven on the bus |
| rdata | output | DW | captured read data |

## Verification
The bench builds the block with a 16-bit bus, LEN_T3 of 2, LEN_T4 of 3, LEN_T6 of 2 and two synchroniser stages. With these values the cycles before T5 add up to an odd or an even count depending on the number of waits, so both parities of the EW rule are reached. The other phase lengths stay at one period, which brings in the shortest possible phases. Wait bursts of several lengths cover zero, one and many added periods. An internal access runs with the wait input held high. Back-to-back requests arrive on both `ck_out` levels, which exercises the start alignment.

// File: rtl/emc_pkg.sv
package emc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_T4   = 3'd4,
      PH_T5   = 3'd5,
      PH_T6   = 3'd6,
      PH_EW   = 3'd7
   } phase_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/emc_wait_sync.sv
module emc_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("emc_wait_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/emc_phase_fsm.sv
module emc_phase_fsm
   import emc_pkg::*;
#(
   parameter int LEN_T1 = 1,
   parameter int LEN_T2 = 1,
   parameter int LEN_T3 = 1,
   parameter int LEN_T4 = 2,
   parameter int LEN_T5 = 1,
   parameter int LEN_T6 = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   start_internal,
   input  logic   wait_s,
   output phase_e phase,
   output logic   ck,
   output logic   accept,
   output logic   t4_end,
   output logic   done
);
   localparam int MAXLEN = max_of(max_of(max_of(LEN_T1, LEN_T2), max_of(LEN_T3, LEN_T4)),
                                  max_of(LEN_T5, LEN_T6));
   localparam int CW = (MAXLEN < 2) ? 1 : $clog2(MAXLEN);

   generate
      if (LEN_T1 < 1 || LEN_T2 < 1 || LEN_T3 < 1 || LEN_T4 < 1 || LEN_T5 < 1 || LEN_T6 < 1)
      begin : g_bad_len
         $error("emc_phase_fsm: every phase length must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          waited;
   logic          internal_q;
   logic [CW-1:0] last_cnt;
   logic          at_last;
   logic          stretch;

   always_comb begin
      unique case (phase)
         PH_T1:   last_cnt = CW'(LEN_T1 - 1);
         PH_T2:   last_cnt = CW'(LEN_T2 - 1);
         PH_T3:   last_cnt = CW'(LEN_T3 - 1);
         PH_T4:   last_cnt = CW'(LEN_T4 - 1);
         PH_T5:   last_cnt = CW'(LEN_T5 - 1);
         PH_T6:   last_cnt = CW'(LEN_T6 - 1);
         default: last_cnt = '0;
      endcase
   end

   assign at_last = (cnt == last_cnt);
   assign accept  = (phase == PH_IDLE) && start && !ck;
   assign stretch = (phase == PH_T4) && at_last && wait_s && !internal_q;
   assign t4_end  = (phase == PH_T4) && at_last && !stretch;
   assign done    = (phase == PH_T6) && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         ck         <= 1'b0;
         waited     <= 1'b0;
         internal_q <= 1'b0;
      end else begin
         ck <= ~ck;
         if (accept) begin
            phase      <= PH_T1;
            cnt        <= '0;
            waited     <= 1'b0;
            internal_q <= start_internal;
         end else if (phase == PH_EW) begin
            phase <= PH_T5;
            cnt   <= '0;
         end else if (phase != PH_IDLE) begin
            if (stretch) begin
               waited <= 1'b1;
            end else if (at_last) begin
               cnt <= '0;
               unique case (phase)
                  PH_T1:   phase <= PH_T2;
                  PH_T2:   phase <= PH_T3;
                  PH_T3:   phase <= PH_T4;
                  PH_T4:   phase <= (waited && ck) ? PH_EW : PH_T5;
                  PH_T5:   phase <= PH_T6;
                  default: phase <= PH_IDLE;
               endcase
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R1: T4 hands over only to EW or T5
   a_r1_t4_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(phase) == PH_T4 && phase != PH_T4) |-> (phase == PH_T5 || phase == PH_EW));
   // R6: EW only after a stretched T4, with the bus clock low
   a_r6_ew_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EW) |-> (waited && !ck && $past(phase) == PH_T4));
   // R6: T5 after waits always opens on a rising bus clock edge
   a_r6_t5_rising: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T5 && $past(phase) != PH_T5 && waited) |-> ck);
   // R5: internal access never stretches T4
   a_r5_internal_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T4 && at_last && internal_q) |=> (phase != PH_T4));
   // R1: T1 opens with the bus clock high
   a_r1_t1_rising: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T1 && $past(phase) == PH_IDLE) |-> ck);
endmodule

// File: rtl/emc_strobe_dec.sv
module emc_strobe_dec
   import emc_pkg::*;
#(
   parameter int DW = 32,
   localparam int NB = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  phase_e        phase,
   input  logic          we_q,
   input  logic          late_q,
   input  logic [NB-1:0] be_q,
   input  logic [DW-1:0] addr_q,
   input  logic [DW-1:0] wdata_q,
   output logic          ale,
   output logic          ce_n,
   output logic          rd_n,
   output logic [NB-1:0] wr_n,
   output logic          ad_oe,
   output logic [DW-1:0] ad_out
);
   logic in_strobe_core;
   logic wr_window;

   assign in_strobe_core = (phase == PH_T3) || (phase == PH_T4) || (phase == PH_EW);
   assign wr_window      = we_q && (in_strobe_core || (!late_q && phase == PH_T2));

   assign ale    = (phase == PH_T1);
   assign ce_n   = !(in_strobe_core || phase == PH_T2 || phase == PH_T5);
   assign rd_n   = !(!we_q && in_strobe_core);
   assign ad_oe  = (phase == PH_T1) || (we_q && phase != PH_IDLE);
   assign ad_out = (phase == PH_T1) ? addr_q : wdata_q;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign wr_n[b] = !(wr_window && be_q[b]);
      end
   endgenerate

   // R7: address latch and chip enable never overlap
   a_r7_ale_ce: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ce_n);
   // R8: a write strobe is only low inside chip enable
   a_r8_wr_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_n != {NB{1'b1}}) |-> (!ce_n && ad_oe));
   // R10: read and write strobes never overlap
   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (wr_n == {NB{1'b1}}));
endmodule

// File: rtl/emc_cycle_seq.sv
module emc_cycle_seq
   import emc_pkg::*;
#(
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_T1      = 1,
   parameter int LEN_T2      = 1,
   parameter int LEN_T3      = 1,
   parameter int LEN_T4      = 2,
   parameter int LEN_T5      = 1,
   parameter int LEN_T6      = 1,
   localparam int NB         = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_we,
   input  logic          start_late,
   input  logic          start_internal,
   input  logic [DW-1:0] start_addr,
   input  logic [DW-1:0] start_wdata,
   input  logic [NB-1:0] start_be,
   input  logic          mem_wait,
   input  logic [DW-1:0] ad_in,
   output logic          ck_out,
   output logic [2:0]    phase,
   output logic          busy,
   output logic          done,
   output logic          ale,
   output logic          ce_n,
   output logic          rd_n,
   output logic [NB-1:0] wr_n,
   output logic          ad_oe,
   output logic [DW-1:0] ad_out,
   output logic [DW-1:0] rdata
);
   generate
      if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
         $error("emc_cycle_seq: DW must be a positive multiple of 8");
      end
   endgenerate

   phase_e        ph;
   logic          wait_s;
   logic          accept;
   logic          t4_end;
   logic          we_q, late_q;
   logic [NB-1:0] be_q;
   logic [DW-1:0] addr_q, wdata_q;

   emc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(mem_wait), .sync_out(wait_s)
   );

   emc_phase_fsm #(
      .LEN_T1(LEN_T1), .LEN_T2(LEN_T2), .LEN_T3(LEN_T3),
      .LEN_T4(LEN_T4), .LEN_T5(LEN_T5), .LEN_T6(LEN_T6)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .start_internal(start_internal),
      .wait_s(wait_s), .phase(ph), .ck(ck_out), .accept(accept),
      .t4_end(t4_end), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         late_q  <= 1'b0;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            we_q    <= start_we;
            late_q  <= start_late;
            be_q    <= start_be;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
         end
         if (t4_end && !we_q) rdata <= ad_in;
      end
   end

   emc_strobe_dec #(.DW(DW)) u_dec (
      .clk(clk), .rst_n(rst_n), .phase(ph), .we_q(we_q), .late_q(late_q),
      .be_q(be_q), .addr_q(addr_q), .wdata_q(wdata_q), .ale(ale), .ce_n(ce_n),
      .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .ad_out(ad_out)
   );

   assign phase = ph;
   assign busy  = (ph != PH_IDLE);

   // R11: completion pulse lies inside T6 and lasts one cycle
   a_r11_done_t6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (phase == 3'd6));
   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/emc_cycle_seq_test.sv
module emc_cycle_seq_test;
   localparam int DW = 16;
   localparam int NB = DW / 8;
   localparam int SY = 2;
   localparam int L1 = 1, L2 = 1, L3 = 2, L4 = 3, L5 = 1, L6 = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0, start_we = 1'b0, start_late = 1'b0, start_internal = 1'b0;
   logic [DW-1:0] start_addr = '0, start_wdata = '0, ad_in = '0;
   logic [NB-1:0] start_be = '0;
   logic          mem_wait = 1'b0;
   logic          ck_out, busy, done, ale, ce_n, rd_n, ad_oe;
   logic [2:0]    phase;
   logic [NB-1:0] wr_n;
   logic [DW-1:0] ad_out, rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   emc_cycle_seq #(
      .DW(DW), .SYNC_STAGES(SY), .LEN_T1(L1), .LEN_T2(L2), .LEN_T3(L3),
      .LEN_T4(L4), .LEN_T5(L5), .LEN_T6(L6)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_we(start_we),
      .start_late(start_late), .start_internal(start_internal),
      .start_addr(start_addr), .start_wdata(start_wdata), .start_be(start_be),
      .mem_wait(mem_wait), .ad_in(ad_in), .ck_out(ck_out), .phase(phase),
      .busy(busy), .done(done), .ale(ale), .ce_n(ce_n), .rd_n(rd_n),
      .wr_n(wr_n), .ad_oe(ad_oe), .ad_out(ad_out), .rdata(rdata)
   );

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural reference
   int          m_ph = 0, m_cnt = 0, m_waits = 0;
   bit          m_ck = 0, m_waited = 0, m_ew = 0, m_int = 0;
   bit          m_we = 0, m_late = 0;
   bit [NB-1:0] m_be = '0;
   bit [DW-1:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
   bit          m_sq[$] = '{0, 0};

   function automatic int len_of(input int p);
      case (p)
         1: return L1;
         2: return L2;
         3: return L3;
         4: return L4;
         5: return L5;
         default: return L6;
      endcase
   endfunction

   always @(posedge clk) begin
      bit ws;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_ck = 0; m_waited = 0; m_we = 0; m_late = 0;
         m_be = '0; m_addr = '0; m_wdata = '0; m_rdata = '0; m_sq = '{0, 0};
      end else begin
         ws = m_sq[SY-1];
         if (m_ph == 0) begin
            if (start && !m_ck) begin
               m_ph = 1; m_cnt = 0; m_waited = 0; m_waits = 0; m_ew = 0;
               m_we = start_we; m_late = start_late; m_int = start_internal;
               m_be = start_be; m_addr = start_addr; m_wdata = start_wdata;
            end
         end else if (m_ph == 7) begin
            m_ph = 5; m_cnt = 0;
         end else if (m_cnt < len_of(m_ph) - 1) begin
            m_cnt++;
         end else if (m_ph == 4 && ws && !m_int) begin
            m_waited = 1; m_waits++;
         end else begin
            m_cnt = 0;
            if (m_ph == 4) begin
               if (!m_we) m_rdata = ad_in;
               m_ew = m_waited && m_ck;
               m_ph = m_ew ? 7 : 5;
            end else if (m_ph == 6) m_ph = 0;
            else m_ph++;
         end
         m_sq.push_front(mem_wait);
         void'(m_sq.pop_back());
         m_ck = !m_ck;
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      bit core, wrw;
      bit [NB-1:0] exp_wr;
      if (rst_n) begin
         core = (m_ph == 3 || m_ph == 4 || m_ph == 7);
         wrw  = m_we && (core || (!m_late && m_ph == 2));
         for (int b = 0; b < NB; b++) exp_wr[b] = !(wrw && m_be[b]);
         check("R1", "phase", 64'(phase), 64'(m_ph));
         check("R3", "ck_out", 64'(ck_out), 64'(m_ck));
         check("R7", "ale", 64'(ale), 64'(m_ph == 1));
         check("R7", "ce_n", 64'(ce_n), 64'(!(core || m_ph == 2 || m_ph == 5)));
         check("R8", "wr_n", 64'(wr_n), 64'(exp_wr));
         check("R9", "ad_oe", 64'(ad_oe), 64'((m_ph == 1) || (m_we && m_ph != 0)));
         if (ad_oe) check("R9", "ad_out", 64'(ad_out), 64'((m_ph == 1) ? m_addr : m_wdata));
         check("R10", "rd_n", 64'(rd_n), 64'(!(!m_we && core)));
         check("R10", "rdata", 64'(rdata), 64'(m_rdata));
         check("R11", "busy", 64'(busy), 64'(m_ph != 0));
         check("R11", "done", 64'(done), 64'(m_ph == 6 && m_cnt == L6 - 1));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   int ph_len[8];

   task automatic run_access(input bit we, input bit late, input bit intl,
                             input bit [DW-1:0] addr, input bit [DW-1:0] data,
                             input bit [NB-1:0] be, input int wait_len);
      int waited_cycles = 0;
      bit wait_started = 0;
      bit seen_done = 0;
      for (int i = 0; i < 8; i++) ph_len[i] = 0;
      start = 1; start_we = we; start_late = late; start_internal = intl;
      start_addr = addr; start_wdata = data; start_be = be; ad_in = ~addr;
      while (!seen_done) begin
         @(negedge clk);
         if (busy) start = 0;
         ph_len[phase]++;
         if (phase == 3'd2 && !wait_started && wait_len > 0) begin
            wait_started = 1; mem_wait = 1;
         end
         if (mem_wait) begin
            waited_cycles++;
            if (waited_cycles > wait_len) mem_wait = 0;
         end
         if (done) seen_done = 1;
      end
      mem_wait = 0;
      check("R2", "T1 length", 64'(ph_len[1]), 64'(L1));
      check("R2", "T2 length", 64'(ph_len[2]), 64'(L2));
      check("R2", "T3 length", 64'(ph_len[3]), 64'(L3));
      check("R2", "T5 length", 64'(ph_len[5]), 64'(L5));
      check("R2", "T6 length", 64'(ph_len[6]), 64'(L6));
      if (intl) check("R5", "internal T4 length", 64'(ph_len[4]), 64'(L4));
      else      check("R4", "T4 length", 64'(ph_len[4]), 64'(L4 + m_waits));
      check("R6", "EW count", 64'(ph_len[7]), 64'(m_ew));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R12", "reset phase", 64'(phase), 64'(0));
      check("R12", "reset ck_out", 64'(ck_out), 64'(0));
      check("R12", "reset busy/done", 64'({busy, done}), 64'(0));
      check("R12", "reset strobes", 64'({ce_n, rd_n, wr_n}), 64'({2'b11, {NB{1'b1}}}));
      check("R12", "reset ale/oe", 64'({ale, ad_oe}), 64'(0));
      rst_n = 1;
      @(negedge clk);
      run_access(1, 0, 0, 16'h1234, 16'hABCD, 2'b11, 0);  // early write, no wait
      run_access(1, 1, 0, 16'h2222, 16'h5A5A, 2'b01, 1);  // late write, one wait
      run_access(0, 0, 0, 16'h3333, 16'h0000, 2'b11, 2);  // read, short wait
      run_access(0, 0, 0, 16'h4444, 16'h0000, 2'b11, 3);
      run_access(0, 1, 0, 16'h5555, 16'h0000, 2'b10, 20); // many waits
      run_access(1, 0, 0, 16'h6666, 16'h1111, 2'b10, 4);
      run_access(1, 1, 1, 16'h7777, 16'h2222, 2'b11, 10); // internal, wait ignored
      check("R5", "internal no waits", 64'(m_waits), 64'(0));
      @(negedge clk);
      run_access(0, 0, 0, 16'h8888, 16'h0000, 2'b01, 0);
      run_access(1, 1, 0, 16'h9999, 16'h3C3C, 2'b11, 5);
      run_access(0, 0, 0, 16'hAAAA, 16'h0000, 2'b11, 6);
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule